// File: doc/BRIEF.md
# SD Card Clock Divider Control

This block holds the clock-control register of an SD host controller and generates the card clock from the base clock. The base clock is 150 MHz in the intended system. An 8-bit divider code selects one of ten division ratios. The ratios step linearly through 1, 2, 3 and 4, then double from 8 up to 256. Writes to the register go through a simple single-cycle strobe. The register value is always visible on a read bus.

Software brings the clock up in four steps:

1. Clear the register.
2. Write the divider code with the internal-enable bit set.
3. Poll until the internal-stable bit reads 1. The block reports this a fixed number of base cycles after enable, far inside the 20 ms that software waits.
4. Rewrite the same code with card-enable also set.

The card clock is gated only during its low phase, so turning it on or off never truncates a pulse. Writing zero stops everything.

Top module: `sdclk_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `rd_data` reads 0x0000 and `card_clk` is low until a write enables it.
- R2: Register layout: bits 15:8 hold the divider code, bit 0 is internal-enable and bit 2 is card-enable. Bit 1 is internal-stable, which is read-only, and writes to it are ignored. Bits 7:3 always read zero.
- R3: Internal-stable reads 1 exactly 16 base-clock cycles after the write that sets internal-enable, and not before. It is never 1 while internal-enable is 0.
- R4: A write that clears internal-enable, or that changes the divider code, clears internal-stable in the same cycle. A write that keeps both the code and internal-enable leaves internal-stable set.
- R5: The divider codes map to ratios as follows: code 0 gives /1, code 1 gives /2, code 3 gives /3 and code 2 gives /4. The codes 4, 8, 16, 32, 64 and 128 give /8, /16, /32, /64, /128 and /256.
- R6: For even ratios the card clock has 50% duty. Ratio 3 gives one base cycle high followed by two low. Ratio 1 passes the base clock through unchanged.
- R7: Any divider code outside the set in R5 (for example 5, 6 or 255) divides by 256.
- R8: `card_clk` stays low whenever internal-enable or card-enable is clear.
- R9: Setting or clearing card-enable at any phase of the divided clock never produces a shortened high pulse. Every high pulse lasts the full half-period.
- R10: Writing 0x0000 while the clock runs stops the card clock and reads back 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock feeding the divider |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Current register value, including the stable bit |
| card_clk | output | 1 | Gated, divided card clock |

## Verification
The bench builds the block with its default stability delay of 16 cycles and the default 8-bit divider code. At that size every valid code, including the 256 ratio, can be measured over two full periods of the card clock. Each of the 256 code values is written and read back. Several undefined codes are measured to confirm that they fall back to /256. Card-enable is toggled at many phases of a /8 clock to catch any runt pulse.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CODE_W   = 8;
  localparam int RATIO_W  = CODE_W + 1;
  localparam int REG_W    = 16;
  localparam int EN_BIT   = 0;
  localparam int STB_BIT  = 1;
  localparam int CEN_BIT  = 2;
  localparam int CODE_LSB = 8;

  // Code to ratio: 0 -> 1, 3 -> 3, single-bit code c -> 2c, anything else -> max.
  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    if (code == '0)
      return RATIO_W'(1);
    else if (code == CODE_W'(3))
      return RATIO_W'(3);
    else if ($countones(code) == 1)
      return {code, 1'b0};
    else
      return RATIO_W'(1) << CODE_W;
  endfunction

  // Number of base cycles the divided clock stays high per period.
  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] ratio);
    if (ratio == RATIO_W'(3))
      return RATIO_W'(1);
    else
      return ratio >> 1;
  endfunction
endpackage

// File: rtl/sdclk_reg.sv
module sdclk_reg
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [CODE_W-1:0] code_o,
  output logic              int_en_o,
  output logic              card_en_o,
  output logic              stable_o
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

  logic [CODE_W-1:0] code_q, code_d;
  logic              int_en_q, int_en_d;
  logic              card_en_q, card_en_d;
  logic              stable_q, stable_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              restart;
  logic              ce;

  always_comb begin
    code_d    = code_q;
    int_en_d  = int_en_q;
    card_en_d = card_en_q;
    stable_d  = stable_q;
    cnt_d     = cnt_q;
    restart   = 1'b0;
    if (wr_en) begin
      code_d    = wr_data[CODE_LSB +: CODE_W];
      int_en_d  = wr_data[EN_BIT];
      card_en_d = wr_data[CEN_BIT];
      restart   = !wr_data[EN_BIT] || (wr_data[CODE_LSB +: CODE_W] != code_q);
    end
    if (restart) begin
      cnt_d    = '0;
      stable_d = 1'b0;
    end else if (int_en_q && !stable_q) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(STABLE_CYCLES - 1))
        stable_d = 1'b1;
    end
  end

  assign ce = wr_en || (int_en_q && !stable_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= '0;
      int_en_q  <= 1'b0;
      card_en_q <= 1'b0;
      stable_q  <= 1'b0;
      cnt_q     <= '0;
    end else if (ce) begin
      code_q    <= code_d;
      int_en_q  <= int_en_d;
      card_en_q <= card_en_d;
      stable_q  <= stable_d;
      cnt_q     <= cnt_d;
    end
  end

  assign code_o    = code_q;
  assign int_en_o  = int_en_q;
  assign card_en_o = card_en_q;
  assign stable_o  = stable_q;
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               div_q,
  output logic               div_nxt
);
  logic [CODE_W-1:0]  cnt_q, cnt_d;
  logic [RATIO_W-1:0] last;
  logic [RATIO_W-1:0] half;

  assign last = ratio - RATIO_W'(1);
  assign half = high_len(ratio);

  always_comb begin
    if (!run)
      cnt_d = '0;
    else if ({1'b0, cnt_q} >= last)
      cnt_d = '0;
    else
      cnt_d = cnt_q + CODE_W'(1);
    div_nxt = run && ({1'b0, cnt_d} < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_nxt;
    end
  end
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bypass,
  input  logic div_q,
  input  logic div_nxt,
  output logic card_clk
);
  logic en_q, en_d;
  logic en_n;

  // Divided path: the enable may only move on an edge where the clock goes or stays low.
  assign en_d = div_nxt ? en_q : run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= 1'b0;
    else
      en_q <= en_d;
  end

  // Undivided path: the enable changes on the falling edge, during the low phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      en_n <= 1'b0;
    else
      en_n <= run && bypass;
  end

  assign card_clk = bypass ? (clk & en_n) : (div_q & en_q);
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             card_clk
);
  logic [1:0]         rst_sync;
  logic               rst_sync_n;
  logic [CODE_W-1:0]  code;
  logic               int_en;
  logic               card_en;
  logic               stable;
  logic [RATIO_W-1:0] ratio;
  logic               div_q;
  logic               div_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  sdclk_reg #(.STABLE_CYCLES(STABLE_CYCLES)) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .code_o    (code),
    .int_en_o  (int_en),
    .card_en_o (card_en),
    .stable_o  (stable)
  );

  assign ratio = code_to_ratio(code);

  sdclk_div u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (int_en),
    .ratio   (ratio),
    .div_q   (div_q),
    .div_nxt (div_nxt)
  );

  sdclk_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (int_en && card_en),
    .bypass   (ratio == RATIO_W'(1)),
    .div_q    (div_q),
    .div_nxt  (div_nxt),
    .card_clk (card_clk)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[CODE_LSB +: CODE_W]  = code;
    rd_data[EN_BIT]              = int_en;
    rd_data[STB_BIT]             = stable;
    rd_data[CEN_BIT]             = card_en;
  end
endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic        div_q,
  input logic        gate_en
);
  // R3: stable only while enabled
  assert_stable_has_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> rd_data[0]);

  // R3: stable rises only with an unchanged code
  assert_stable_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> $stable(rd_data[15:8]));

  // R4: dropping enable drops stable at once
  assert_stable_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[0]) |-> !rd_data[1]);

  // R8: divider idle once internal enable is off
  assert_div_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> !div_q);

  // R9: gate enable moves only while the divided clock is low
  assert_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_en) |-> !div_q);
endmodule

bind sdclk_ctrl sdclk_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rd_data (rd_data),
  .div_q   (div_q),
  .gate_en (u_gate.en_q)
);

// File: tb/sdclk_ctrl_test.sv
module sdclk_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        card_clk;

  int checks = 0;
  int errors = 0;
  logic mon_en = 1'b0;
  int   mon_run = 0;
  int   mon_bad = 0;
  int   mon_pulses = 0;

  sdclk_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .card_clk (card_clk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_stable();
    for (int i = 0; i < 40 && !rd_data[1]; i++) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (card_clk !== 1'b0) highs++;
      #5;
      if (card_clk !== 1'b0) highs++;
    end
    check(req, highs, 0);
  endtask

  task automatic measure(input logic [7:0] code, input int ratio, input string req);
    int   high = (ratio == 3) ? 1 : ratio / 2;
    int   bad = 0;
    logic s, prev;
    wr({code, 8'h01});
    wait_stable();
    wr({code, 8'h05});
    repeat (3) @(negedge clk);
    if (ratio == 1) begin
      for (int i = 0; i < 8; i++) begin
        @(posedge clk); #2;
        if (card_clk !== 1'b1) bad++;
        #5;
        if (card_clk !== 1'b0) bad++;
      end
    end else begin
      prev = 1'b1;
      s    = 1'b0;
      for (int i = 0; i < 3 * ratio + 4; i++) begin
        @(posedge clk); #2;
        s = card_clk;
        if (s && !prev) break;
        prev = s;
      end
      if (!(s && !prev)) bad++;
      for (int j = 1; j < 2 * ratio; j++) begin
        @(posedge clk); #2;
        if (card_clk !== ((j % ratio) < high)) bad++;
      end
    end
    check(req, bad, 0);
    wr(16'h0000);
  endtask

  // Length of every high pulse while monitoring a /8 clock (R9).
  always @(posedge clk) begin
    #2;
    if (card_clk === 1'b1) mon_run++;
    else begin
      if (mon_run > 0 && mon_en) begin
        mon_pulses++;
        if (mon_run != 4) mon_bad++;
      end
      mon_run = 0;
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", rd_data, 16'h0000);
    check("R1 reset card_clk", card_clk, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {rd_data, 15'd0, card_clk}, 32'h0);

    // R2: readback of every code, reserved and stable bits ignored
    bad = 0;
    for (int c = 0; c < 256; c++) begin
      wr({c[7:0], 8'hFA});
      if (rd_data !== {c[7:0], 8'h00}) bad++;
    end
    check("R2 code sweep", bad, 0);
    wr(16'h0000);
    wr(16'hFFFF);
    check("R2 all ones", rd_data, 16'hFF05);
    wr(16'h0000);

    // R3: stability exactly 16 cycles after enable
    wr(16'h0201);
    repeat (15) @(negedge clk);
    check("R3 not yet stable", rd_data[1], 1'b0);
    @(negedge clk);
    check("R3 stable at 16", rd_data[1], 1'b1);

    // R4
    wr(16'h0205);
    check("R4 same code keeps stable", rd_data, 16'h0207);
    wr(16'h0405);
    check("R4 code change clears", rd_data, 16'h0405);
    repeat (16) @(negedge clk);
    check("R4 restabilized", rd_data, 16'h0407);
    wr(16'h0404);
    check("R4 enable clear clears", rd_data, 16'h0404);
    wr(16'h0000);

    // R5/R6: every valid code
    measure(8'd0,   1,   "R5/R6 code 0 ratio 1");
    measure(8'd1,   2,   "R5/R6 code 1 ratio 2");
    measure(8'd3,   3,   "R5/R6 code 3 ratio 3");
    measure(8'd2,   4,   "R5/R6 code 2 ratio 4");
    for (int k = 2; k < 8; k++)
      measure(8'(1 << k), 2 << k, $sformatf("R5/R6 code %0d", 1 << k));

    // R7: undefined codes
    measure(8'd5,   256, "R7 code 5");
    measure(8'd6,   256, "R7 code 6");
    measure(8'd255, 256, "R7 code 255");

    // R8
    wr(16'h0401);
    wait_stable();
    quiet(40, "R8 card enable clear");
    wr(16'h0404);
    quiet(40, "R8 internal enable clear");
    wr(16'h0000);

    // R9: toggle card enable at many phases of /8
    wr(16'h0401);
    wait_stable();
    mon_en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wr(16'h0405);
      repeat (20 + k) @(negedge clk);
      wr(16'h0401);
      repeat (13 + k) @(negedge clk);
    end
    repeat (16) @(negedge clk);
    mon_en = 1'b0;
    check("R9 no runt pulse", mon_bad, 0);
    check("R9 pulses seen", mon_pulses > 20, 1'b1);

    // R10
    wr(16'h0101);
    wait_stable();
    wr(16'h0105);
    repeat (10) @(negedge clk);
    wr(16'h0000);
    check("R10 readback zero", rd_data, 16'h0000);
    quiet(40, "R10 clock stopped");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule